// File: doc/BRIEF.md
# PHY Management Serial Bus Master

This block runs single register transactions on a two-wire PHY management bus: a clock line (MDC) and a bidirectional data line that is split here into an output value, an output enable and an input. A request carries a read/write flag, a 5-bit PHY address, a 5-bit register number and 16 bits of write data. While the request is running, `busy` is high. When the frame has finished, `done` pulses for one cycle, and on a read `rd_data` then holds the 16 bits returned by the PHY.

Every frame is 65 bits long. Each bit lasts one full MDC period. The bit is launched while MDC is low, and the data line is sampled at the end of the high phase. The parameter `DIV_HALF` gives the number of system clocks in one MDC half period. A frame holds these fields in order:

- a 32-bit preamble,
- start and opcode fields,
- the two address fields,
- a turnaround,
- the 16-bit data field,
- one trailing clock with the driver off.

After that the bus goes back to idle: MDC low, data low, driver off.

Top module: `mdio_master`

## Requirements
- R1: While `rst` is high and on the cycle after it, `mdc`, `mdio_o`, `mdio_oe`, `busy`, `done` and `rd_data` are all 0.
- R2: Bit periods are counted from the cycle after a request is accepted. Each bit period holds `mdc` low for `DIV_HALF` clocks and then high for `DIV_HALF` clocks. `mdio_o` and `mdio_oe` change only when `mdc` goes low, and `mdc` is high only while `busy` is high.
- R3: Frame bits 0 to 31 are the preamble: `mdio_o`=1 with `mdio_oe`=1.
- R4: Bits 32 and 33 are the start field 0,1. Bits 34 and 35 are the opcode: 0,1 for a write and 1,0 for a read. All four are driven.
- R5: Bits 36 to 40 carry the PHY address and bits 41 to 45 carry the register number. Both fields are sent MSB first and driven.
- R6: Bits 46 and 47 are the turnaround. On a write they are driven as 1 then 0. On a read `mdio_oe` is 0 for both.
- R7: On a write, bits 48 to 63 carry the write data MSB first, driven.
- R8: Bit 64 is a trailing clock with `mdio_oe`=0 and `mdio_o`=0. Every frame contains exactly 65 rising edges of `mdc`.
- R9: On a read, `mdio_oe` is 0 for bits 48 to 63. `mdio_i` is sampled on the last system clock of each of their high phases, and the 16 samples are assembled MSB first. They appear on `rd_data` from the `done` cycle onward. A write leaves `rd_data` unchanged.
- R10: `done` is high for exactly one cycle: the cycle after the last high phase of bit 64. In that cycle `busy` is 0 and the bus is idle (`mdc`, `mdio_o`, `mdio_oe` all 0).
- R11: When `req_valid` is high while `busy` is 0, the request is accepted and `busy` is 1 from the next cycle. `req_valid` while `busy` is 1 has no effect on the running frame.
- R12: A synchronous reset in the middle of a frame returns the bus to idle and clears `busy` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transaction (taken when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Data to write |
| mdio_i | input | 1 | Data line input |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data from the last completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
Two functions can fall in the same cycle. The completion of one frame (`done`, with `busy` dropping) can meet the acceptance of the next request. A synchronous reset can also land in the middle of a bit period.

The bench provokes the first case by holding `req_valid` high from inside a running frame. The follow-on frame must then start on the edge that ends the `done` cycle, with no extra idle bit and with the new fields, not the ones of any request pulsed mid-frame.

A behavioural model computes the whole frame from a queue of expected bits, including the tristated turnaround and data windows. The bench compares every output against it on every clock, and also compares them across a reset asserted partway through a read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 65;
  localparam int PRE_BITS   = 32;
  localparam int DATA_FIRST = 48;
  localparam int DATA_LAST  = 63;
  localparam int TRAIL_IDX  = FRAME_BITS - 1;
  localparam int IDX_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic        write;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] wdata;
  } mdio_req_t;

  typedef struct packed {
    logic oe;
    logic val;
  } mdio_bit_t;

  // Output enable and value of frame bit `idx` for request `r`
  function automatic mdio_bit_t frame_bit(input mdio_req_t r, input logic [IDX_W-1:0] idx);
    int k;
    mdio_bit_t b;
    k = int'(idx);
    b = '{oe: 1'b0, val: 1'b0};
    if (k < PRE_BITS)        b = '{oe: 1'b1, val: 1'b1};
    else if (k == 32)        b = '{oe: 1'b1, val: 1'b0};
    else if (k == 33)        b = '{oe: 1'b1, val: 1'b1};
    else if (k == 34)        b = '{oe: 1'b1, val: !r.write};
    else if (k == 35)        b = '{oe: 1'b1, val: r.write};
    else if (k <= 40)        b = '{oe: 1'b1, val: r.phy[3'(40 - k)]};
    else if (k <= 45)        b = '{oe: 1'b1, val: r.regn[3'(45 - k)]};
    else if (k == 46)        b = '{oe: r.write, val: r.write};
    else if (k == 47)        b = '{oe: r.write, val: 1'b0};
    else if (k <= DATA_LAST) b = '{oe: r.write, val: r.write & r.wdata[4'(DATA_LAST - k)]};
    return b;
  endfunction

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(DIV_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2: the counter never passes the last clock of a half period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DIV_HALF - 1));

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (en) dout <= {dout[W-2:0], din};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);

  logic             busy_q, done_q, mdc_q, o_q, oe_q;
  logic [15:0]      rd_q;
  logic [IDX_W-1:0] idx_q;
  mdio_req_t        req_q, new_req;
  mdio_bit_t        first_bit, next_bit;
  logic             tick, low_end, high_end, last_bit, in_rx_win;
  logic [15:0]      rx_word;

  assign new_req   = '{write: req_write, phy: req_phy, regn: req_reg, wdata: req_wdata};
  assign first_bit = frame_bit(new_req, '0);
  assign next_bit  = frame_bit(req_q, idx_q + 1'b1);

  mdio_half_timer #(.DIV_HALF(DIV_HALF)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_q),
    .tick (tick)
  );

  assign low_end   = tick && !mdc_q;
  assign high_end  = tick && mdc_q;
  assign last_bit  = (idx_q == IDX_W'(TRAIL_IDX));
  assign in_rx_win = !req_q.write && (idx_q >= IDX_W'(DATA_FIRST)) && (idx_q <= IDX_W'(DATA_LAST));

  mdio_rx_shift #(.W(16)) u_rx (
    .clk  (clk),
    .rst  (rst),
    .en   (high_end && in_rx_win),
    .din  (mdio_i),
    .dout (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mdc_q  <= 1'b0;
      o_q    <= 1'b0;
      oe_q   <= 1'b0;
      rd_q   <= '0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          req_q        <= new_req;
          busy_q       <= 1'b1;
          idx_q        <= '0;
          mdc_q        <= 1'b0;
          {oe_q, o_q}  <= first_bit;
        end
      end else if (low_end) begin
        mdc_q <= 1'b1;
      end else if (high_end) begin
        mdc_q <= 1'b0;
        if (last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          o_q    <= 1'b0;
          oe_q   <= 1'b0;
          if (!req_q.write) rd_q <= rx_word;
        end else begin
          idx_q       <= idx_q + 1'b1;
          {oe_q, o_q} <= next_bit;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rd_q;
  assign mdc     = mdc_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

  // R10: completion cycle leaves the bus idle and not busy
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mdc && !mdio_oe && !mdio_o));

  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: data line is steady across the high phase
  a_r2_stable_high: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R2: clock only toggles within a transaction
  a_r2_mdc_busy: assert property (@(posedge clk) disable iff (rst)
    mdc |-> busy);

  // R11: a running transaction keeps its captured request
  a_r11_hold_req: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(req_q));

  // R6 / R9: read releases the line from turnaround onward
  a_r6_read_release: assert property (@(posedge clk) disable iff (rst)
    (busy && !req_q.write && idx_q >= IDX_W'(46)) |-> !mdio_oe);

  // R8: trailing bit is never driven
  a_r8_trail_off: assert property (@(posedge clk) disable iff (rst)
    (busy && last_bit) |-> (!mdio_oe && !mdio_o));

endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/100ps
module mdio_master_tb_top;

  localparam int DIVH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        mdio_i = 1'b0;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  mdio_master #(.DIV_HALF(DIVH)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata), .mdio_i(mdio_i),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 0;

  // ---------------- behavioural reference model ----------------
  bit          exp_o [0:64];
  bit          exp_oe[0:64];
  bit          m_busy = 0, m_done = 0, m_write = 0;
  int          m_idx = 0, m_cyc = 0;
  logic [15:0] m_rd = '0, m_sh = '0;
  logic [15:0] phy_resp = 16'h0000;

  task automatic build_frame(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd);
    int p;
    p = 0;
    for (int i = 0; i < 32; i++) begin exp_o[p] = 1; exp_oe[p] = 1; p++; end
    exp_o[p] = 0; exp_oe[p] = 1; p++;
    exp_o[p] = 1; exp_oe[p] = 1; p++;
    exp_o[p] = wr ? 0 : 1; exp_oe[p] = 1; p++;
    exp_o[p] = wr ? 1 : 0; exp_oe[p] = 1; p++;
    for (int i = 4; i >= 0; i--) begin exp_o[p] = pa[i]; exp_oe[p] = 1; p++; end
    for (int i = 4; i >= 0; i--) begin exp_o[p] = ra[i]; exp_oe[p] = 1; p++; end
    exp_o[p] = wr; exp_oe[p] = wr; p++;
    exp_o[p] = 0;  exp_oe[p] = wr; p++;
    for (int i = 15; i >= 0; i--) begin exp_o[p] = wr & wd[i]; exp_oe[p] = wr; p++; end
    exp_o[p] = 0; exp_oe[p] = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_rd = '0; m_sh = '0; m_idx = 0; m_cyc = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (req_valid) begin
          build_frame(req_write, req_phy, req_reg, req_wdata);
          m_write = req_write; m_busy = 1; m_idx = 0; m_cyc = 0;
        end
      end else if (m_cyc == 2*DIVH-1) begin
        if (!m_write && m_idx >= 48 && m_idx <= 63) m_sh = {m_sh[14:0], mdio_i};
        if (m_idx == 64) begin
          m_busy = 0; m_done = 1;
          if (!m_write) m_rd = m_sh;
        end else begin
          m_idx++; m_cyc = 0;
        end
      end else begin
        m_cyc++;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", req, what, $time, act, exp);
    end
  endtask

  function automatic string bit_req(input int idx, input bit wr);
    if (idx < 32) return "R3";
    if (idx < 36) return "R4";
    if (idx < 46) return "R5";
    if (idx < 48) return "R6";
    if (idx < 64) return wr ? "R7" : "R9";
    return "R8";
  endfunction

  bit prev_mdc = 0;
  int rises = 0;
  bit junk = 0;

  always @(negedge clk) begin
    if (!finished) begin
      if (m_busy) begin
        chk("R2", "mdc", 16'(mdc), 16'(m_cyc >= DIVH));
        chk(bit_req(m_idx, m_write), "mdio_o",  16'(mdio_o),  16'(exp_o[m_idx]));
        chk(bit_req(m_idx, m_write), "mdio_oe", 16'(mdio_oe), 16'(exp_oe[m_idx]));
      end else begin
        chk(rst ? "R1" : "R12", "idle mdc", 16'(mdc), 16'h0);
        chk("R10", "idle mdio_o", 16'(mdio_o), 16'h0);
        chk("R10", "idle mdio_oe", 16'(mdio_oe), 16'h0);
      end
      chk("R11", "busy", 16'(busy), 16'(m_busy));
      chk("R10", "done", 16'(done), 16'(m_done));
      chk("R9", "rd_data", rd_data, m_rd);
      // R8: count rising clock edges within a frame
      if (mdc && !prev_mdc) rises++;
      prev_mdc = mdc;
      if (done) begin
        chk("R8", "mdc rises per frame", 16'(rises), 16'd65);
        rises = 0;
      end
      if (rst) rises = 0;
      // PHY model: drive response only in the read data window, junk elsewhere
      junk = ~junk;
      if (m_busy && !m_write && m_idx >= 48 && m_idx <= 63)
        mdio_i = phy_resp[63 - m_idx];
      else
        mdio_i = junk;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_phy = pa; req_reg = ra; req_wdata = wd;
    do @(negedge clk); while (!(m_busy && m_idx == 0 && m_cyc == 0));
    req_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", 16'(busy), 16'h0);
    chk("R1", "reset rd_data", rd_data, 16'h0);
    rst = 0;

    // R3 R4 R5 R7: write with single-bit patterns
    do_req(1, 5'h01, 5'h00, 16'h8000); wait_idle();
    do_req(1, 5'h1F, 5'h1A, 16'hA5C3); wait_idle();
    // R9 R6: reads with varied responses
    phy_resp = 16'h1C57; do_req(0, 5'h02, 5'h03, 16'hFFFF); wait_idle();
    chk("R9", "read word", rd_data, 16'h1C57);
    // R9: write leaves read data alone
    do_req(1, 5'h10, 5'h11, 16'h0001); wait_idle();
    chk("R9", "rd_data after write", rd_data, 16'h1C57);
    phy_resp = 16'hFFFF; do_req(0, 5'h15, 5'h0A, 16'h0000); wait_idle();
    phy_resp = 16'h0000; do_req(0, 5'h0A, 5'h15, 16'h0000); wait_idle();
    chk("R9", "read zero", rd_data, 16'h0000);

    // R11: a pulse mid-frame is ignored
    do_req(1, 5'h03, 5'h04, 16'h1234);
    repeat (40) @(negedge clk);
    req_valid = 1; req_write = 0; req_phy = 5'h1E; req_reg = 5'h1E;
    @(negedge clk); req_valid = 0;
    wait_idle();
    chk("R11", "no follow-on frame", 16'(busy), 16'h0);

    // R10 R11: request held across done starts next frame at once
    phy_resp = 16'h6A39;
    do_req(0, 5'h07, 5'h08, 16'h0);
    repeat (100) @(negedge clk);
    do_req(1, 5'h19, 5'h02, 16'hBEEF);
    wait_idle();
    chk("R9", "read before back-to-back", rd_data, 16'h6A39);

    // R12: reset in the middle of a read
    phy_resp = 16'hC001;
    do_req(0, 5'h05, 5'h06, 16'h0);
    repeat (150) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R12", "busy after mid reset", 16'(busy), 16'h0);
    chk("R12", "mdc after mid reset", 16'(mdc), 16'h0);
    do_req(0, 5'h05, 5'h06, 16'h0); wait_idle();
    chk("R9", "read after reset", rd_data, 16'hC001);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule